// File: doc/BRIEF.md
# Dual Timestamp Queue Unit

This block keeps two first-in first-out queues of 64-bit time values, one for frames that were received and one for frames that were sent. A per-direction strobe input captures the free-running time input into that direction's queue on the clock edge where it is high. Deciding which frames earn a stamp is done elsewhere; this block only stores and hands out the values.

Software reaches both queues through one 32-bit register bus. It reads a status register to learn how many stamps are waiting, clears the command register, writes a one-hot command to ask for one stamp, polls until the same command bit reads back as 1, and then fetches the stamp as a high word followed by a low word. Each queue keeps a sticky flag when a stamp had to be dropped because the queue was full. One command value clears the whole unit.

Top module: `stamp_queue_unit`

## Requirements
- R1: After rst_n is released every mapped register reads 0: command at 0x50, receive status at 0x54, transmit status at 0x58, receive data high/low at 0x60/0x64, transmit data high/low at 0x68/0x6C.
- R2: On a clock edge where tx_strobe (or rx_strobe) is 1, time_now is appended to the transmit (or receive) queue, and the count field in bits [4:0] of that direction's status register rises by one.
- R3: A bus write to 0x50 with bit 0 set pops the transmit queue, with bit 2 set pops the receive queue. The matching command bit reads 0 in the cycle after the write and 1 from the following cycle on, by which time the oldest stamp sits in that direction's data registers and the count has fallen by one.
- R4: A held stamp reads with bits [63:32] at the high offset (0x60 receive, 0x68 transmit) and bits [31:0] at the low offset (0x64 receive, 0x6C transmit).
- R5: The two queues are independent: pushes, pops, counts and held data of one direction never change those of the other.
- R6: Any write to 0x50 other than 0xA clears both done bits and cancels pending pops; writing 0 leaves the held data registers unchanged.
- R7: A pop requested on an empty queue still sets its done bit, leaves the held data unchanged and keeps the count at 0.
- R8: Each queue holds 16 stamps. A push on a full queue with no pop in the same cycle drops the new stamp, keeps the stored ones, and sets a sticky overflow flag in bit 31 of that direction's status register.
- R9: A push and a pop on the same queue in the same cycle leave its count unchanged, and the pushed stamp is delivered by a later pop.
- R10: Writing 0xA to 0x50 empties both queues and clears their counts, overflow flags, held data and done bits.
- R11: Reads of any address outside the mapped offsets return 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| time_now | input | 64 | Current time value to capture |
| tx_strobe | input | 1 | Capture time_now into the transmit queue |
| rx_strobe | input | 1 | Capture time_now into the receive queue |
| bus_wr | input | 1 | Register write enable |
| bus_addr | input | 8 | Register byte offset |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data, combinational from bus_addr |

## Verification
A wrong pointer or count inside a queue shows up at the data registers on the very next pop, as a stamp that is out of order, repeated or stale, and at the status register in the cycle after the faulty push or pop. A lost pending flag shows as a done bit that never rises two cycles after the command write, while an overflow flag that leaks or sticks wrongly is visible in bit 31 immediately. Filling one queue to its limit and draining it completely, with values that differ in every word, exposes each of these within the pass over all sixteen slots.

// File: rtl/stamp_queue_pkg.sv
`timescale 1ns/1ps
package stamp_queue_pkg;
   localparam logic [7:0] OFS_CMD     = 8'h50;
   localparam logic [7:0] OFS_RX_STAT = 8'h54;
   localparam logic [7:0] OFS_TX_STAT = 8'h58;
   localparam logic [7:0] OFS_RX_HI   = 8'h60;
   localparam logic [7:0] OFS_RX_LO   = 8'h64;
   localparam logic [7:0] OFS_TX_HI   = 8'h68;
   localparam logic [7:0] OFS_TX_LO   = 8'h6C;

   localparam int LANE_TX   = 0;
   localparam int LANE_RX   = 1;
   localparam int NUM_LANES = 2;

   localparam logic [31:0] CMD_CLEAR_ALL = 32'h0000_000A;

   // command bit that requests (and reports) a pop for a given lane
   function automatic int lane_cmd_bit(input int lane);
      return (lane == LANE_TX) ? 0 : 2;
   endfunction
endpackage

// File: rtl/stamp_fifo.sv
`timescale 1ns/1ps
module stamp_fifo #(
   parameter int TS_W  = 64,
   parameter int DEPTH = 16,
   localparam int PTR_W = $clog2(DEPTH),
   localparam int CNT_W = $clog2(DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             push,
   input  logic [TS_W-1:0]  din,
   input  logic             pop,
   output logic [TS_W-1:0]  dout,
   output logic             take,
   output logic [CNT_W-1:0] cnt,
   output logic             ovf
);
   initial begin
      assert (DEPTH >= 2) else $error("stamp_fifo: DEPTH must be at least 2");
      assert (TS_W >= 1)  else $error("stamp_fifo: TS_W must be positive");
   end

   logic [TS_W-1:0]  mem [DEPTH];
   logic [PTR_W-1:0] wr_ptr, rd_ptr, wr_nxt, rd_nxt;
   logic             full, empty, accept, drop;

   assign full   = (cnt == CNT_W'(DEPTH));
   assign empty  = (cnt == '0);
   assign take   = pop && !empty;
   assign accept = push && (!full || take);
   assign drop   = push && full && !take;
   assign dout   = mem[rd_ptr];

   generate
      if ((1 << PTR_W) == DEPTH) begin : g_pow2
         assign wr_nxt = wr_ptr + 1'b1;
         assign rd_nxt = rd_ptr + 1'b1;
      end else begin : g_wrap
         assign wr_nxt = (wr_ptr == PTR_W'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
         assign rd_nxt = (rd_ptr == PTR_W'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (accept) mem[wr_ptr] <= din;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         cnt    <= '0;
         ovf    <= 1'b0;
      end else if (clr) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         cnt    <= '0;
         ovf    <= 1'b0;
      end else begin
         if (accept) wr_ptr <= wr_nxt;
         if (take)   rd_ptr <= rd_nxt;
         if (drop)   ovf    <= 1'b1;
         case ({accept, take})
            2'b10:   cnt <= cnt + 1'b1;
            2'b01:   cnt <= cnt - 1'b1;
            default: cnt <= cnt;
         endcase
      end
   end
endmodule

// File: rtl/stamp_lane.sv
`timescale 1ns/1ps
module stamp_lane #(
   parameter int TS_W  = 64,
   parameter int DEPTH = 16,
   localparam int CNT_W = $clog2(DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             strobe,
   input  logic [TS_W-1:0]  stamp,
   input  logic             cmd_wr,
   input  logic             cmd_req,
   output logic [TS_W-1:0]  held,
   output logic             pending,
   output logic             done,
   output logic [CNT_W-1:0] cnt,
   output logic             ovf
);
   logic             pop_go, take;
   logic [TS_W-1:0]  head;

   // a new command write overrides a pop that is still pending
   assign pop_go = pending && !cmd_wr;

   stamp_fifo #(.TS_W(TS_W), .DEPTH(DEPTH)) u_fifo (
      .clk  (clk),
      .rst_n(rst_n),
      .clr  (clr),
      .push (strobe),
      .din  (stamp),
      .pop  (pop_go),
      .dout (head),
      .take (take),
      .cnt  (cnt),
      .ovf  (ovf)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pending <= 1'b0;
         done    <= 1'b0;
         held    <= '0;
      end else if (clr) begin
         pending <= 1'b0;
         done    <= 1'b0;
         held    <= '0;
      end else begin
         if (cmd_wr) begin
            pending <= cmd_req;
            done    <= 1'b0;
         end else if (pending) begin
            pending <= 1'b0;
            done    <= 1'b1;
         end
         if (take) held <= head;
      end
   end
endmodule

// File: rtl/stamp_queue_unit.sv
`timescale 1ns/1ps
module stamp_queue_unit
   import stamp_queue_pkg::*;
#(
   parameter int TS_W   = 64,
   parameter int BUS_W  = 32,
   parameter int ADDR_W = 8,
   parameter int DEPTH  = 16,
   localparam int CNT_W = $clog2(DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [TS_W-1:0]   time_now,
   input  logic              tx_strobe,
   input  logic              rx_strobe,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [BUS_W-1:0]  bus_wdata,
   output logic [BUS_W-1:0]  bus_rdata
);
   initial begin
      assert (TS_W == 2 * BUS_W) else $error("stamp_queue_unit: TS_W must be twice BUS_W");
      assert (ADDR_W >= 8)       else $error("stamp_queue_unit: ADDR_W too narrow for the map");
      assert (CNT_W < BUS_W)     else $error("stamp_queue_unit: count does not fit status word");
   end

   logic                             cmd_wr, clr_all;
   logic [NUM_LANES-1:0]             lane_push, lane_req;
   logic [NUM_LANES-1:0]             lane_pend, lane_done, lane_ovf;
   logic [NUM_LANES-1:0][CNT_W-1:0]  lane_cnt;
   logic [NUM_LANES-1:0][TS_W-1:0]   lane_held;
   logic [NUM_LANES-1:0][BUS_W-1:0]  lane_stat;
   logic [BUS_W-1:0]                 cmd_view;

   assign cmd_wr  = bus_wr && (bus_addr == ADDR_W'(OFS_CMD));
   assign clr_all = cmd_wr && (bus_wdata == BUS_W'(CMD_CLEAR_ALL));

   assign lane_push[LANE_TX] = tx_strobe;
   assign lane_push[LANE_RX] = rx_strobe;

   generate
      for (genvar l = 0; l < NUM_LANES; l++) begin : g_lane
         assign lane_req[l] = bus_wdata[lane_cmd_bit(l)];

         stamp_lane #(.TS_W(TS_W), .DEPTH(DEPTH)) u_lane (
            .clk    (clk),
            .rst_n  (rst_n),
            .clr    (clr_all),
            .strobe (lane_push[l]),
            .stamp  (time_now),
            .cmd_wr (cmd_wr && !clr_all),
            .cmd_req(lane_req[l]),
            .held   (lane_held[l]),
            .pending(lane_pend[l]),
            .done   (lane_done[l]),
            .cnt    (lane_cnt[l]),
            .ovf    (lane_ovf[l])
         );

         assign lane_stat[l] = {lane_ovf[l], {(BUS_W-1-CNT_W){1'b0}}, lane_cnt[l]};
      end
   endgenerate

   always_comb begin
      cmd_view = '0;
      for (int l = 0; l < NUM_LANES; l++) cmd_view[lane_cmd_bit(l)] = lane_done[l];
   end

   always_comb begin
      bus_rdata = '0;
      if (bus_addr == ADDR_W'(OFS_CMD))          bus_rdata = cmd_view;
      else if (bus_addr == ADDR_W'(OFS_RX_STAT)) bus_rdata = lane_stat[LANE_RX];
      else if (bus_addr == ADDR_W'(OFS_TX_STAT)) bus_rdata = lane_stat[LANE_TX];
      else if (bus_addr == ADDR_W'(OFS_RX_HI))   bus_rdata = lane_held[LANE_RX][TS_W-1:BUS_W];
      else if (bus_addr == ADDR_W'(OFS_RX_LO))   bus_rdata = lane_held[LANE_RX][BUS_W-1:0];
      else if (bus_addr == ADDR_W'(OFS_TX_HI))   bus_rdata = lane_held[LANE_TX][TS_W-1:BUS_W];
      else if (bus_addr == ADDR_W'(OFS_TX_LO))   bus_rdata = lane_held[LANE_TX][BUS_W-1:0];
   end
endmodule

module stamp_queue_chk
   import stamp_queue_pkg::*;
#(
   parameter int BUS_W  = 32,
   parameter int ADDR_W = 8,
   parameter int DEPTH  = 16,
   localparam int CNT_W = $clog2(DEPTH + 1)
) (
   input logic                            clk,
   input logic                            rst_n,
   input logic                            bus_wr,
   input logic [ADDR_W-1:0]               bus_addr,
   input logic [BUS_W-1:0]                bus_wdata,
   input logic [BUS_W-1:0]                bus_rdata,
   input logic [NUM_LANES-1:0][CNT_W-1:0] lane_cnt,
   input logic [NUM_LANES-1:0]            lane_pend,
   input logic [NUM_LANES-1:0]            lane_done,
   input logic [NUM_LANES-1:0]            lane_ovf
);
   logic cw, clr;
   logic mapped;
   assign cw  = bus_wr && (bus_addr == ADDR_W'(OFS_CMD));
   assign clr = cw && (bus_wdata == BUS_W'(CMD_CLEAR_ALL));
   assign mapped = (bus_addr == ADDR_W'(OFS_CMD))     || (bus_addr == ADDR_W'(OFS_RX_STAT)) ||
                   (bus_addr == ADDR_W'(OFS_TX_STAT)) || (bus_addr == ADDR_W'(OFS_RX_HI))   ||
                   (bus_addr == ADDR_W'(OFS_RX_LO))   || (bus_addr == ADDR_W'(OFS_TX_HI))   ||
                   (bus_addr == ADDR_W'(OFS_TX_LO));

   a_r11_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
      !mapped |-> bus_rdata == '0);

   generate
      for (genvar l = 0; l < NUM_LANES; l++) begin : g_chk
         a_r8_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
            lane_cnt[l] <= CNT_W'(DEPTH));
         a_r3_done_follows: assert property (@(posedge clk) disable iff (!rst_n)
            lane_pend[l] && !cw |=> lane_done[l] && !lane_pend[l]);
         a_r6_write_clears_done: assert property (@(posedge clk) disable iff (!rst_n)
            cw |=> !lane_done[l]);
         a_r8_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
            lane_ovf[l] && !clr |=> lane_ovf[l]);
         a_r10_clear_all: assert property (@(posedge clk) disable iff (!rst_n)
            clr |=> lane_cnt[l] == '0 && !lane_ovf[l] && !lane_pend[l]);
         a_r9_count_step: assert property (@(posedge clk) disable iff (!rst_n)
            !clr |=> (lane_cnt[l] == $past(lane_cnt[l])) ||
                     (lane_cnt[l] == $past(lane_cnt[l]) + 1'b1) ||
                     (lane_cnt[l] + 1'b1 == $past(lane_cnt[l])));
      end
   endgenerate
endmodule

bind stamp_queue_unit stamp_queue_chk #(.BUS_W(BUS_W), .ADDR_W(ADDR_W), .DEPTH(DEPTH)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .bus_wr   (bus_wr),
   .bus_addr (bus_addr),
   .bus_wdata(bus_wdata),
   .bus_rdata(bus_rdata),
   .lane_cnt (lane_cnt),
   .lane_pend(lane_pend),
   .lane_done(lane_done),
   .lane_ovf (lane_ovf)
);

// File: tb/sim_stamp_queue_unit.sv
`timescale 1ns/1ps
module sim_stamp_queue_unit;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [63:0] time_now = '0;
   logic        tx_strobe = 1'b0;
   logic        rx_strobe = 1'b0;
   logic        bus_wr = 1'b0;
   logic [7:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;

   int checks = 0;
   int errors = 0;
   bit finished = 0;

   always #2.5 clk = ~clk;

   stamp_queue_unit u0 (
      .clk(clk), .rst_n(rst_n), .time_now(time_now),
      .tx_strobe(tx_strobe), .rx_strobe(rx_strobe),
      .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
      .bus_rdata(bus_rdata)
   );

   function automatic logic [63:0] tx_val(input int i);
      return {32'h7100_0000 + 32'(i), 32'h0F0F_0000 ^ (32'(i) * 32'd13)};
   endfunction
   function automatic logic [63:0] rx_val(input int i);
      return {32'hC200_0000 + 32'(i * 3), 32'h5A5A_0000 + 32'(i * 7)};
   endfunction

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%08h expected=%08h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_wr = 1'b0; bus_wdata = '0;
   endtask

   task automatic rd_now(input logic [7:0] a, output logic [31:0] d);
      bus_addr = a;
      #0.5;
      d = bus_rdata;
   endtask

   task automatic rd(input logic [7:0] a, output logic [31:0] d);
      @(negedge clk);
      rd_now(a, d);
   endtask

   task automatic push(input bit rx, input logic [63:0] v);
      @(negedge clk);
      time_now = v;
      if (rx) rx_strobe = 1'b1; else tx_strobe = 1'b1;
      @(negedge clk);
      tx_strobe = 1'b0; rx_strobe = 1'b0;
   endtask

   // pop one entry and check it against exp; bit position 0 = transmit, 2 = receive
   task automatic pop_check(input bit rx, input logic [63:0] exp, input string tag);
      logic [31:0] d;
      logic [31:0] mask;
      mask = rx ? 32'h4 : 32'h1;
      wr(8'h50, 32'h0);
      wr(8'h50, mask);
      rd_now(8'h50, d);
      check({tag, " R3 not ready yet"}, d, 32'h0);
      rd(8'h50, d);
      check({tag, " R3 done bit"}, d, mask);
      rd(rx ? 8'h60 : 8'h68, d);
      check({tag, " R4 high word"}, d, exp[63:32]);
      rd(rx ? 8'h64 : 8'h6C, d);
      check({tag, " R4 low word"}, d, exp[31:0]);
   endtask

   initial begin
      #(200000 * 5);
      if (!finished) begin
         errors++; checks++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("  Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      logic [31:0] d;
      logic [7:0]  regs [7];
      regs[0] = 8'h50; regs[1] = 8'h54; regs[2] = 8'h58; regs[3] = 8'h60;
      regs[4] = 8'h64; regs[5] = 8'h68; regs[6] = 8'h6C;

      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      for (int k = 0; k < 7; k++) begin
         rd(regs[k], d);
         check("R1 reset value", d, 32'h0);
      end
      // R11 unmapped offsets
      for (int a = 0; a < 256; a += 4) begin
         if (a != 'h50 && a != 'h54 && a != 'h58 && a != 'h60 &&
             a != 'h64 && a != 'h68 && a != 'h6C) begin
            rd(8'(a), d);
            check("R11 unmapped read", d, 32'h0);
         end
      end

      // R2 fill transmit queue to its limit
      for (int i = 0; i < 16; i++) begin
         push(0, tx_val(i));
         rd_now(8'h58, d);
         check("R2 tx count", d, 32'(i + 1));
      end
      // R8 push on full is dropped, overflow flag in bit 31
      push(0, 64'hDEAD_BEEF_DEAD_BEEF);
      rd_now(8'h58, d);
      check("R8 overflow and count", d, 32'h8000_0010);
      rd(8'h54, d);
      check("R5 rx count untouched", d, 32'h0);

      // receive queue gets its own entries
      for (int i = 0; i < 3; i++) push(1, rx_val(i));
      rd(8'h54, d);
      check("R2 rx count", d, 32'd3);

      // R3/R4/R8 drain transmit queue in order, overflow stays set
      for (int i = 0; i < 16; i++) begin
         pop_check(0, tx_val(i), "tx pop");
         rd(8'h58, d);
         check("R8 count and sticky overflow", d, 32'h8000_0000 | 32'(15 - i));
      end

      // R7 pop on empty queue
      pop_check(0, tx_val(15), "R7 empty pop");
      rd(8'h58, d);
      check("R7 count stays zero", d, 32'h8000_0000);

      // R6 writing 0 clears done bits and keeps data
      wr(8'h50, 32'h0);
      rd_now(8'h50, d);
      check("R6 done cleared", d, 32'h0);
      rd(8'h6C, d);
      check("R6 data kept", d, tx_val(15)[31:0]);

      // R5 drain receive queue, transmit data unaffected
      for (int i = 0; i < 3; i++) pop_check(1, rx_val(i), "rx pop");
      rd(8'h68, d);
      check("R5 tx data intact", d, tx_val(15)[63:32]);
      rd(8'h54, d);
      check("R5 rx count zero", d, 32'h0);

      // R9 push and pop in the same cycle on the receive queue
      push(1, rx_val(10));
      wr(8'h50, 32'h0);
      @(negedge clk);
      bus_wr = 1'b1; bus_addr = 8'h50; bus_wdata = 32'h4;
      @(negedge clk);
      bus_wr = 1'b0; bus_wdata = '0;
      time_now = rx_val(11); rx_strobe = 1'b1;
      @(negedge clk);
      rx_strobe = 1'b0;
      rd_now(8'h54, d);
      check("R9 count unchanged", d, 32'd1);
      rd(8'h60, d);
      check("R9 popped older entry", d, rx_val(10)[63:32]);
      pop_check(1, rx_val(11), "R9 later pop");

      // R10 clear-all command
      push(0, tx_val(40));
      push(0, tx_val(41));
      push(1, rx_val(40));
      wr(8'h50, 32'hA);
      for (int k = 0; k < 7; k++) begin
         rd(regs[k], d);
         check("R10 cleared", d, 32'h0);
      end
      push(0, tx_val(50));
      pop_check(0, tx_val(50), "R10 works after clear");

      finished = 1;
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule